// File: doc/BRIEF.md
# Hot-Plug Slot Command Completion Logic

This block holds the slot control and slot status registers of a hot-plug capable downstream port. Configuration writes land on the control register. A write may turn into a hot-plug command, which goes to a downstream indicator and power controller over a request/acknowledge handshake. When the controller acknowledges, the block sets a command-completed flag in the status register and pulses an output for one cycle. Software clears the flag by writing a one to it.

A mode input chooses how writes become commands. In compliant mode, every control write on a hot-plug capable port is a command. In legacy mode, a write is a command only when it changes one of the control fields: interlock, power controller, power indicator or attention indicator. On a port that is not hot-plug capable, writes update the register and never issue a command. One further command can be queued while an earlier one is in flight.

Top module: `slot_cmd_ctrl`

## Requirements
- R1: While reset is high and on the cycle after it, cmd_req, cmd_data, cc_pulse and rd_data are all zero, and both registers read back as zero.
- R2: A write with wr_addr equal to the control offset (default 12'hA8) stores all 16 data bits. A read of that offset presents the stored value on rd_data one clock after rd_addr is applied.
- R3: In legacy mode (compliant_mode=0), a control write that leaves bits 11:6 unchanged raises no cmd_req, and command-completed stays clear.
- R4: In legacy mode, a control write that changes bit 11, bit 10, bits 9:8 or bits 7:6 raises cmd_req on the next clock, with cmd_data equal to the new register value.
- R5: In compliant mode (compliant_mode=1), every control write on a hot-plug capable port raises a command, including a write that changes only bits outside 11:6.
- R6: When hp_capable=0, a control write updates the register but raises no command.
- R7: Command-completed is bit 4 of the status register (default offset 12'hAA). It is set by the clock edge at which cmd_req and cmd_ack are both high, and cmd_req falls on that same edge. cmd_ack has no effect while cmd_req is low.
- R8: Once raised, cmd_req stays high, with cmd_data unchanged, until cmd_ack is seen.
- R9: A command triggered while cmd_req is high is queued, and further triggers merge into it. After the acknowledge, cmd_req is low for one cycle and then rises with cmd_data equal to the control register value at that time.
- R10: A status write with bit 4 set clears command-completed, and a write with bit 4 clear leaves it unchanged. A set and a clear on the same edge leave the flag set.
- R11: cc_pulse is high for exactly one cycle, the cycle after the edge at which command-completed goes from 0 to 1. An acknowledge while the flag is already set gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hp_capable | input | 1 | Port is hot-plug capable |
| compliant_mode | input | 1 | 1: every write is a command; 0: only control-field changes count |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | 12 | Configuration write offset |
| wr_data | input | 16 | Configuration write data |
| rd_addr | input | 12 | Configuration read offset |
| rd_data | output | 16 | Registered read data, one cycle after rd_addr |
| cmd_req | output | 1 | Command request to the downstream controller |
| cmd_data | output | 16 | Control register value carried by the command |
| cmd_ack | input | 1 | Controller acknowledge |
| cc_pulse | output | 1 | One-cycle pulse when command-completed rises |

## Verification
cmd_req and cmd_data are due one rising edge after the triggering write, or two edges after the acknowledge for a queued command. Command-completed and cc_pulse are due one edge after the acknowledge, and rd_data one edge after the read address. The bench drives inputs on the falling edge and advances a cycle model of the requirements by exactly one step per rising edge. It compares every output at the following falling edge, so each expected value is checked in the cycle the requirements place it. Directed sequences cover each control field, merging of queued writes, set-versus-clear collisions, and the non-capable port. Seeded random traffic then runs in all four combinations of mode and capability.

// File: rtl/slot_cmd_pkg.sv
package slot_cmd_pkg;
  typedef enum logic {
    ISS_IDLE = 1'b0,
    ISS_BUSY = 1'b1
  } iss_state_t;
endpackage

// File: rtl/slot_ctrl_reg.sv
module slot_ctrl_reg #(
  parameter int          DATA_W     = 16,
  parameter logic [15:0] FIELD_MASK = 16'h0FC0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_ctrl,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              hp_capable,
  input  logic              compliant_mode,
  output logic [DATA_W-1:0] ctrl_q,
  output logic [DATA_W-1:0] ctrl_next,
  output logic              cmd_trig
);
  localparam logic [DATA_W-1:0] MASK = DATA_W'(FIELD_MASK);

  logic field_changed;

  always_comb begin
    ctrl_next     = wr_ctrl ? wr_data : ctrl_q;
    field_changed = |((wr_data ^ ctrl_q) & MASK);
    cmd_trig      = wr_ctrl && hp_capable && (compliant_mode || field_changed);
  end

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= '0;
    else     ctrl_q <= ctrl_next;
  end

  // A control write must be visible in the register after the edge.
  assert_ctrl_store_R2: assert property (@(posedge clk) disable iff (rst)
    wr_ctrl |=> ctrl_q == $past(wr_data));
  // A port without hot-plug support never triggers a command.
  assert_no_trig_incapable_R6: assert property (@(posedge clk) disable iff (rst)
    !hp_capable |-> !cmd_trig);
endmodule

// File: rtl/slot_cmd_issuer.sv
module slot_cmd_issuer
  import slot_cmd_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_trig,
  input  logic [DATA_W-1:0] ctrl_next,
  input  logic              cmd_ack,
  output logic              cmd_req,
  output logic [DATA_W-1:0] cmd_data,
  output logic              cmd_done
);
  iss_state_t st_q;
  logic       pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ISS_IDLE;
      pend_q   <= 1'b0;
      cmd_data <= '0;
    end else begin
      case (st_q)
        ISS_IDLE: begin
          if (cmd_trig || pend_q) begin
            st_q     <= ISS_BUSY;
            cmd_data <= ctrl_next;
            pend_q   <= 1'b0;
          end
        end
        ISS_BUSY: begin
          if (cmd_trig) pend_q <= 1'b1;
          if (cmd_ack)  st_q   <= ISS_IDLE;
        end
        default: st_q <= ISS_IDLE;
      endcase
    end
  end

  assign cmd_req  = (st_q == ISS_BUSY);
  assign cmd_done = cmd_req && cmd_ack;

  assert_req_hold_R8: assert property (@(posedge clk) disable iff (rst)
    cmd_req && !cmd_ack |=> cmd_req);
  assert_data_stable_R8: assert property (@(posedge clk) disable iff (rst)
    cmd_req && !cmd_ack |=> $stable(cmd_data));
  assert_drop_after_ack_R7: assert property (@(posedge clk) disable iff (rst)
    cmd_req && cmd_ack |=> !cmd_req);
  assert_queue_issue_R9: assert property (@(posedge clk) disable iff (rst)
    !cmd_req && pend_q |=> cmd_req);
endmodule

// File: rtl/slot_status_reg.sv
module slot_status_reg #(
  parameter int DATA_W = 16,
  parameter int CC_BIT = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_cc,
  input  logic              clr_cc,
  output logic              cc_q,
  output logic              cc_pulse,
  output logic [DATA_W-1:0] status_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cc_q     <= 1'b0;
      cc_pulse <= 1'b0;
    end else begin
      cc_pulse <= set_cc && !cc_q;
      if (set_cc)      cc_q <= 1'b1;
      else if (clr_cc) cc_q <= 1'b0;
    end
  end

  always_comb begin
    status_q         = '0;
    status_q[CC_BIT] = cc_q;
  end

  assert_cc_set_R7: assert property (@(posedge clk) disable iff (rst)
    set_cc |=> cc_q);
  assert_pulse_flag_R11: assert property (@(posedge clk) disable iff (rst)
    cc_pulse |-> cc_q);
  assert_pulse_single_R11: assert property (@(posedge clk) disable iff (rst)
    cc_pulse |=> !cc_pulse);
  assert_clear_R10: assert property (@(posedge clk) disable iff (rst)
    clr_cc && !set_cc |=> !cc_q);
endmodule

// File: rtl/slot_cmd_ctrl.sv
module slot_cmd_ctrl #(
  parameter int              ADDR_W     = 12,
  parameter int              DATA_W     = 16,
  parameter int              CC_BIT     = 4,
  parameter logic [15:0]     FIELD_MASK = 16'h0FC0,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 12'hA8,
  parameter logic [ADDR_W-1:0] STAT_OFS = 12'hAA
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hp_capable,
  input  logic              compliant_mode,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              cmd_req,
  output logic [DATA_W-1:0] cmd_data,
  input  logic              cmd_ack,
  output logic              cc_pulse
);
  logic              wr_ctrl, wr_stat, clr_cc;
  logic              cmd_trig, cmd_done, cc_q;
  logic [DATA_W-1:0] ctrl_q, ctrl_next, status_q;

  assign wr_ctrl = wr_en && (wr_addr == CTRL_OFS);
  assign wr_stat = wr_en && (wr_addr == STAT_OFS);
  assign clr_cc  = wr_stat && wr_data[CC_BIT];

  slot_ctrl_reg #(.DATA_W(DATA_W), .FIELD_MASK(FIELD_MASK)) u_ctrl (
    .clk(clk), .rst(rst), .wr_ctrl(wr_ctrl), .wr_data(wr_data),
    .hp_capable(hp_capable), .compliant_mode(compliant_mode),
    .ctrl_q(ctrl_q), .ctrl_next(ctrl_next), .cmd_trig(cmd_trig));

  slot_cmd_issuer #(.DATA_W(DATA_W)) u_iss (
    .clk(clk), .rst(rst), .cmd_trig(cmd_trig), .ctrl_next(ctrl_next),
    .cmd_ack(cmd_ack), .cmd_req(cmd_req), .cmd_data(cmd_data),
    .cmd_done(cmd_done));

  slot_status_reg #(.DATA_W(DATA_W), .CC_BIT(CC_BIT)) u_stat (
    .clk(clk), .rst(rst), .set_cc(cmd_done), .clr_cc(clr_cc),
    .cc_q(cc_q), .cc_pulse(cc_pulse), .status_q(status_q));

  always_ff @(posedge clk) begin
    if (rst)                    rd_data <= '0;
    else if (rd_addr == CTRL_OFS) rd_data <= ctrl_q;
    else if (rd_addr == STAT_OFS) rd_data <= status_q;
    else                        rd_data <= '0;
  end

  assert_incapable_no_req_R6: assert property (@(posedge clk) disable iff (rst)
    !hp_capable && !cmd_req && !$past(cmd_req) |=> !cmd_req);
  assert_pulse_after_ack_R11: assert property (@(posedge clk) disable iff (rst)
    cc_pulse |-> $past(cmd_req && cmd_ack) && !$past(cc_q));
endmodule

// File: tb/test_slot_cmd_ctrl.sv
`timescale 1ns/1ps
module test_slot_cmd_ctrl;
  localparam logic [11:0] A_CTRL = 12'hA8;
  localparam logic [11:0] A_STAT = 12'hAA;
  localparam logic [15:0] FMASK  = 16'h0FC0;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hp_capable = 1'b1, compliant_mode = 1'b0;
  logic wr_en = 1'b0, cmd_ack = 1'b0;
  logic [11:0] wr_addr = '0, rd_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data, cmd_data;
  logic cmd_req, cc_pulse;

  int checks = 0, errors = 0;

  // model state
  logic [15:0] m_ctrl = '0, m_data = '0, m_rd = '0;
  logic m_cc = 0, m_req = 0, m_pend = 0, m_pulse = 0;

  always #2.5 clk = ~clk;

  slot_cmd_ctrl i_slot_cmd_ctrl (
    .clk(clk), .rst(rst), .hp_capable(hp_capable), .compliant_mode(compliant_mode),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .cmd_req(cmd_req), .cmd_data(cmd_data), .cmd_ack(cmd_ack),
    .cc_pulse(cc_pulse));

  task automatic chk(input logic ok, input string tag, input logic [15:0] act,
                     input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] stat_val(input logic cc);
    return {11'b0, cc, 4'b0};
  endfunction

  // One clock: drive at falling edge, step the model, compare at next falling edge.
  task automatic step(input logic we, input logic [11:0] wa, input logic [15:0] wd,
                      input logic ak, input logic [11:0] ra);
    logic wctrl, wstat, trig, done;
    logic [15:0] nctrl;
    wr_en = we; wr_addr = wa; wr_data = wd; cmd_ack = ak; rd_addr = ra;
    wctrl = we && wa == A_CTRL;
    wstat = we && wa == A_STAT;
    trig  = wctrl && hp_capable && (compliant_mode || (((wd ^ m_ctrl) & FMASK) != 0));
    nctrl = wctrl ? wd : m_ctrl;
    done  = m_req && ak;
    m_rd    = (ra == A_CTRL) ? m_ctrl : (ra == A_STAT) ? stat_val(m_cc) : 16'h0;
    m_pulse = done && !m_cc;
    if (done) m_cc = 1'b1;
    else if (wstat && wd[4]) m_cc = 1'b0;
    if (m_req) begin
      if (trig) m_pend = 1'b1;
      if (ak) m_req = 1'b0;
    end else if (trig || m_pend) begin
      m_req = 1'b1; m_data = nctrl; m_pend = 1'b0;
    end
    m_ctrl = nctrl;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; cmd_ack = 1'b0;
    chk(cmd_req == m_req, "R3 R4 R5 R6 R8 R9 cmd_req", {15'b0, cmd_req}, {15'b0, m_req});
    if (m_req) chk(cmd_data == m_data, "R4 R8 R9 cmd_data", cmd_data, m_data);
    chk(cc_pulse == m_pulse, "R11 cc_pulse", {15'b0, cc_pulse}, {15'b0, m_pulse});
    chk(rd_data == m_rd, "R2 R7 R10 rd_data", rd_data, m_rd);
  endtask

  task automatic idle(input logic [11:0] ra);
    step(1'b0, 12'h0, 16'h0, 1'b0, ra);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [15:0] d;
    int unused_seed;
    unused_seed = $urandom(32'd20240517);
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(cmd_req == 0 && cc_pulse == 0 && rd_data == 0 && cmd_data == 0, "R1 reset",
        {cmd_req, cc_pulse, 14'b0} | rd_data | cmd_data, 16'h0);
    rst = 1'b0;
    idle(A_CTRL);
    chk(rd_data == 16'h0, "R1 ctrl after reset", rd_data, 16'h0);

    // legacy mode, enable-only write: R3
    step(1'b1, A_CTRL, 16'h0035, 1'b0, A_CTRL);
    chk(cmd_req == 0, "R3 no cmd", {15'b0, cmd_req}, 16'h0);
    idle(A_CTRL);
    chk(rd_data == 16'h0035, "R2 readback", rd_data, 16'h0035);
    idle(A_STAT);
    chk(rd_data[4] == 0, "R3 cc clear", rd_data, 16'h0);

    // each control field: R4, R7, R11
    foreach (FMASK[i]) begin
      if (FMASK[i] && (i == 11 || i == 10 || i == 8 || i == 6)) begin
        d = m_ctrl ^ (16'h1 << i);
        step(1'b1, A_CTRL, d, 1'b0, A_CTRL);
        chk(cmd_req == 1 && cmd_data == d, "R4 field change", cmd_data, d);
        step(1'b0, 12'h0, 16'h0, 1'b1, A_STAT);
        chk(cmd_req == 0, "R7 req drops", {15'b0, cmd_req}, 16'h0);
        chk(cc_pulse == (i == 11), "R11 pulse once", {15'b0, cc_pulse}, {15'b0, i == 11});
        idle(A_STAT);
        chk(rd_data[4] == 1, "R7 cc set", rd_data, 16'h0010);
      end
    end

    // W1C: R10
    step(1'b1, A_STAT, 16'hFFEF, 1'b0, A_STAT);
    idle(A_STAT);
    chk(rd_data[4] == 1, "R10 write0 no effect", rd_data, 16'h0010);
    step(1'b1, A_STAT, 16'h0010, 1'b0, A_STAT);
    idle(A_STAT);
    chk(rd_data[4] == 0, "R10 w1c", rd_data, 16'h0);
    // ack and clear on the same edge: set wins
    step(1'b1, A_CTRL, m_ctrl ^ 16'h0040, 1'b0, A_CTRL);
    step(1'b1, A_STAT, 16'h0010, 1'b1, A_STAT);
    idle(A_STAT);
    chk(rd_data[4] == 1, "R10 set wins", rd_data, 16'h0010);

    // queueing: R9, ack ignored when idle R7
    idle(A_CTRL);
    step(1'b0, 12'h0, 16'h0, 1'b1, A_CTRL);
    chk(cmd_req == 0, "R7 stray ack", {15'b0, cmd_req}, 16'h0);
    step(1'b1, A_CTRL, m_ctrl ^ 16'h0800, 1'b0, A_CTRL);
    step(1'b1, A_CTRL, m_ctrl ^ 16'h0100, 1'b0, A_CTRL);
    d = m_ctrl ^ 16'h0400;
    step(1'b1, A_CTRL, d, 1'b0, A_CTRL);
    step(1'b0, 12'h0, 16'h0, 1'b1, A_CTRL);
    chk(cmd_req == 0, "R9 gap", {15'b0, cmd_req}, 16'h0);
    idle(A_CTRL);
    chk(cmd_req == 1 && cmd_data == d, "R9 queued data", cmd_data, d);
    step(1'b0, 12'h0, 16'h0, 1'b1, A_CTRL);
    idle(A_CTRL);
    chk(cmd_req == 0, "R9 single queue", {15'b0, cmd_req}, 16'h0);

    // compliant: R5
    compliant_mode = 1'b1;
    d = m_ctrl ^ 16'h0008;
    step(1'b1, A_CTRL, d, 1'b0, A_CTRL);
    chk(cmd_req == 1 && cmd_data == d, "R5 enable-only write", cmd_data, d);
    step(1'b0, 12'h0, 16'h0, 1'b1, A_CTRL);
    step(1'b1, A_CTRL, m_ctrl, 1'b0, A_CTRL);
    chk(cmd_req == 1, "R5 identical write", {15'b0, cmd_req}, 16'h1);
    step(1'b0, 12'h0, 16'h0, 1'b1, A_CTRL);

    // not capable: R6
    hp_capable = 1'b0;
    d = m_ctrl ^ 16'h0FC0;
    step(1'b1, A_CTRL, d, 1'b0, A_CTRL);
    chk(cmd_req == 0, "R6 no cmd", {15'b0, cmd_req}, 16'h0);
    idle(A_CTRL);
    chk(rd_data == d, "R6 reg updated", rd_data, d);

    // seeded random traffic in all four mode/capability combinations
    for (int ph = 0; ph < 4; ph++) begin
      hp_capable     = ph[1] ? 1'b0 : 1'b1;
      compliant_mode = ph[0];
      for (int n = 0; n < 800; n++) begin
        logic [1:0]  sel;
        logic [11:0] wa, ra;
        logic [15:0] wd;
        sel = 2'($urandom);
        wa  = (sel == 0) ? A_STAT : (sel == 3) ? 12'h010 : A_CTRL;
        ra  = ($urandom % 2) ? A_CTRL : A_STAT;
        wd  = m_ctrl ^ ((($urandom % 2) != 0) ? (16'($urandom) & FMASK) : 16'h0)
                     ^ (16'($urandom) & ~FMASK);
        step(($urandom % 3) == 0, wa, wd, ($urandom % 3) == 0, ra);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule